// File: doc/BRIEF.md
# Tiled Pixel Address Generator

This unit turns a pixel coordinate into a byte offset inside a tiled image buffer. The caller gives the column and row of the pixel, a code for the pixel size in bytes, the image height in pixels, and a code for the tiling layout. One clock after a valid request, the unit returns the byte offset from the start of the buffer and an error flag. The caller adds the buffer base address and performs the memory access.

All layouts are built from 64-byte microtiles. Pixels inside a microtile are stored row by row. A block is two microtiles by two microtiles, 256 bytes in all. The layouts differ in how microtiles or blocks follow one another in memory. The line layout places microtiles in a single row or a single column. The block-linear layouts store blocks in raster order, one or two blocks wide. The grouped layout stores blocks in columns four blocks wide, one column after another, and can swizzle the block row on odd columns.

Top module: `tile_addr_gen`

## Requirements
- R1: `bpp_code` selects the pixel size in bytes: 0 for 1, 1 for 2, 2 for 4, 3 for 8, 4 for 16. Codes 5 to 7 give `err`=1 and `offset`=0.
- R2: `layout_sel` selects the layout: 0 for microtile line, 1 for block-linear one column, 2 for block-linear two columns, 3 for grouped, 4 for grouped with swizzle. Codes 5 to 7 give `err`=1 and `offset`=0.
- R3: The microtile size in pixels (width x height) is 8x8 for 1 byte, 8x4 for 2 bytes, 4x4 for 4 bytes, 4x2 for 8 bytes and 2x2 for 16 bytes. Inside a microtile the offset is xi*bytes + yi*width*bytes.
- R4: In the microtile line layout the offset is 64*(x/width + y/height) plus the offset inside the microtile.
- R5: In the microtile line layout, a coordinate whose microtile column index and microtile row index are both nonzero gives `err`=1 and `offset`=0.
- R6: In the block-linear and grouped layouts, a pixel in the right microtile of its block adds 64 bytes, and a pixel in the lower microtile adds 128 bytes.
- R7: In a block-linear layout with N columns (N=1 or 2), the offset is 256*(by*N + bx) plus the offset inside the block. Here bx and by are the block column and block row.
- R8: In the grouped layout, let H = ceil(img_h / block height in pixels). The block id is (bx/4)*(H-1)*4 + bx + by*4, and the offset is 256*id plus the offset inside the block.
- R9: In the grouped layout with swizzle, when bit 0 of bx/4 is 1, the block row is XORed with 16 before the id is formed. When that bit is 0, the result equals the unswizzled grouped layout.
- R10: `out_valid` is `in_valid` delayed by one clock. After a clock with `in_valid` low, `offset` and `err` keep their previous values.
- R11: While `rst` is high, and directly after it, `out_valid`, `offset` and `err` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| px_x | input | X_W | Pixel column |
| px_y | input | Y_W | Pixel row |
| bpp_code | input | 3 | Pixel size code |
| img_h | input | H_W | Image height in pixels |
| layout_sel | input | 3 | Layout code |
| out_valid | output | 1 | Result strobe, one clock after the request |
| offset | output | OFF_W | Byte offset within the buffer |
| err | output | 1 | Illegal size code, illegal layout code, or illegal line coordinate |

## Verification
A wrong microtile size decode moves the in-tile offset, or the tile index, on the very next result. This shows most clearly for pixels just past a microtile edge, so the tests place coordinates on both sides of those edges for several pixel sizes. A wrong quadrant bit or block index changes the offset by a multiple of 64 or 256 bytes in the result for that same request. A swizzle applied to the wrong column group appears only when bx/4 is odd, so grouped tests cover both parities, and two image heights exercise the rounding of the block-height count. Latency or hold faults show up as a strobe or value that is wrong in the clock right after a request or an idle clock.

// File: rtl/tile_addr_pkg.sv
package tile_addr_pkg;

    typedef enum logic [2:0] {
        LAY_LINE     = 3'd0,
        LAY_BLK_ONE  = 3'd1,
        LAY_BLK_TWO  = 3'd2,
        LAY_GRP      = 3'd3,
        LAY_GRP_SWZ  = 3'd4
    } layout_e;

    localparam int SWZ_BIT   = 4;
    localparam int UTILE_LG  = 6;
    localparam int BLOCK_LG  = 8;

    // log2 widths of microtile (w, h) and pixel size (c)
    typedef struct packed {
        logic       ok;
        logic [2:0] lw;
        logic [2:0] lh;
        logic [2:0] lc;
    } geom_t;

    function automatic geom_t geom_of(input logic [2:0] code);
        geom_t g;
        g.ok = 1'b1;
        g.lc = code;
        unique case (code)
            3'd0: begin g.lw = 3'd3; g.lh = 3'd3; end
            3'd1: begin g.lw = 3'd3; g.lh = 3'd2; end
            3'd2: begin g.lw = 3'd2; g.lh = 3'd2; end
            3'd3: begin g.lw = 3'd2; g.lh = 3'd1; end
            3'd4: begin g.lw = 3'd1; g.lh = 3'd1; end
            default: begin g.ok = 1'b0; g.lw = 3'd0; g.lh = 3'd0; g.lc = 3'd0; end
        endcase
        return g;
    endfunction

endpackage

// File: rtl/tile_geom_dec.sv
module tile_geom_dec
    import tile_addr_pkg::*;
(
    input  logic [2:0] bpp_code,
    output geom_t      geom
);
    always_comb geom = geom_of(bpp_code);
endmodule

// File: rtl/tile_split.sv
module tile_split
    import tile_addr_pkg::*;
#(
    parameter int X_W = 12,
    parameter int Y_W = 12
) (
    input  logic [X_W-1:0] px_x,
    input  logic [Y_W-1:0] px_y,
    input  geom_t          geom,
    output logic [X_W-1:0] ut_col,
    output logic [Y_W-1:0] ut_row,
    output logic [X_W-1:0] blk_col,
    output logic [Y_W-1:0] blk_row,
    output logic [5:0]     in_tile
);
    localparam int CW = (X_W > Y_W) ? X_W : Y_W;

    logic [X_W-1:0] x_mask;
    logic [Y_W-1:0] y_mask;
    logic [CW-1:0]  x_part;
    logic [CW-1:0]  y_part;
    logic [2:0]     row_sh;

    always_comb begin
        x_mask  = X_W'((1 << geom.lw) - 1);
        y_mask  = Y_W'((1 << geom.lh) - 1);
        ut_col  = px_x >> geom.lw;
        ut_row  = px_y >> geom.lh;
        blk_col = px_x >> (geom.lw + 3'd1);
        blk_row = px_y >> (geom.lh + 3'd1);
        row_sh  = geom.lw + geom.lc;
        x_part  = CW'(px_x & x_mask) << geom.lc;
        y_part  = CW'(px_y & y_mask) << row_sh;
        in_tile = 6'(x_part + y_part);
    end
endmodule

// File: rtl/tile_layout_sel.sv
module tile_layout_sel
    import tile_addr_pkg::*;
#(
    parameter int X_W   = 12,
    parameter int Y_W   = 12,
    parameter int H_W   = 12,
    parameter int OFF_W = 32
) (
    input  geom_t          geom,
    input  logic [2:0]     layout_sel,
    input  logic [H_W-1:0] img_h,
    input  logic [X_W-1:0] ut_col,
    input  logic [Y_W-1:0] ut_row,
    input  logic [X_W-1:0] blk_col,
    input  logic [Y_W-1:0] blk_row,
    input  logic [5:0]     in_tile,
    output logic [OFF_W-1:0] offset,
    output logic           err
);
    logic [OFF_W-1:0] quad;
    logic [OFF_W-1:0] in_blk;
    logic [OFF_W-1:0] bx;
    logic [OFF_W-1:0] by;
    logic [OFF_W-1:0] by_grp;
    logic [OFF_W-1:0] blk_h;
    logic [OFF_W-1:0] grp_h;
    logic [OFF_W-1:0] grp_id;
    logic [OFF_W-1:0] raw;
    logic             bad;
    logic [2:0]       lbh;

    always_comb begin
        lbh    = geom.lh + 3'd1;
        quad   = (ut_col[0] ? OFF_W'(64) : '0) + (ut_row[0] ? OFF_W'(128) : '0);
        in_blk = quad + OFF_W'(in_tile);
        bx     = OFF_W'(blk_col);
        by     = OFF_W'(blk_row);
        blk_h  = OFF_W'(1) << lbh;
        grp_h  = (OFF_W'(img_h) + blk_h - OFF_W'(1)) >> lbh;
        by_grp = by;
        if (layout_sel == LAY_GRP_SWZ && blk_col[2])
            by_grp = by ^ (OFF_W'(1) << SWZ_BIT);
        grp_id = (bx >> 2) * ((grp_h - OFF_W'(1)) << 2) + bx + (by_grp << 2);
        bad    = 1'b0;
        raw    = '0;
        case (layout_sel)
            LAY_LINE: begin
                raw = ((OFF_W'(ut_col) + OFF_W'(ut_row)) << UTILE_LG) + OFF_W'(in_tile);
                bad = (ut_col != '0) && (ut_row != '0);
            end
            LAY_BLK_ONE: raw = (by + bx) << BLOCK_LG | in_blk;
            LAY_BLK_TWO: raw = (((by << 1) + bx) << BLOCK_LG) + in_blk;
            LAY_GRP, LAY_GRP_SWZ: raw = (grp_id << BLOCK_LG) + in_blk;
            default: bad = 1'b1;
        endcase
        err    = bad || !geom.ok;
        offset = err ? '0 : raw;
    end
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
    import tile_addr_pkg::*;
#(
    parameter int X_W   = 12,
    parameter int Y_W   = 12,
    parameter int H_W   = 12,
    parameter int OFF_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [X_W-1:0]   px_x,
    input  logic [Y_W-1:0]   px_y,
    input  logic [2:0]       bpp_code,
    input  logic [H_W-1:0]   img_h,
    input  logic [2:0]       layout_sel,
    output logic             out_valid,
    output logic [OFF_W-1:0] offset,
    output logic             err
);
    geom_t            geom;
    logic [X_W-1:0]   ut_col;
    logic [Y_W-1:0]   ut_row;
    logic [X_W-1:0]   blk_col;
    logic [Y_W-1:0]   blk_row;
    logic [5:0]       in_tile;
    logic [OFF_W-1:0] calc_off;
    logic             calc_err;

    tile_geom_dec u_geom (
        .bpp_code (bpp_code),
        .geom     (geom)
    );

    tile_split #(.X_W(X_W), .Y_W(Y_W)) u_split (
        .px_x    (px_x),
        .px_y    (px_y),
        .geom    (geom),
        .ut_col  (ut_col),
        .ut_row  (ut_row),
        .blk_col (blk_col),
        .blk_row (blk_row),
        .in_tile (in_tile)
    );

    tile_layout_sel #(.X_W(X_W), .Y_W(Y_W), .H_W(H_W), .OFF_W(OFF_W)) u_lay (
        .geom       (geom),
        .layout_sel (layout_sel),
        .img_h      (img_h),
        .ut_col     (ut_col),
        .ut_row     (ut_row),
        .blk_col    (blk_col),
        .blk_row    (blk_row),
        .in_tile    (in_tile),
        .offset     (calc_off),
        .err        (calc_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            offset    <= '0;
            err       <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                offset <= calc_off;
                err    <= calc_err;
            end
        end
    end

    // R1
    bad_bpp_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && bpp_code > 3'd4 |=> err && offset == '0);

    // R2
    bad_layout_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && layout_sel > 3'd4 |=> err && offset == '0);

    // R3
    wide_pixel_align_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && bpp_code == 3'd4 |=> offset[3:0] == 4'd0);

    // R10
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && $stable(offset) && $stable(err));

    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> !out_valid && offset == '0 && !err);
endmodule

// File: tb/tile_addr_gen_tb.sv
module tile_addr_gen_tb;
    localparam int X_W = 12, Y_W = 12, H_W = 12, OFF_W = 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [X_W-1:0]   px_x = '0;
    logic [Y_W-1:0]   px_y = '0;
    logic [2:0]       bpp_code = '0;
    logic [H_W-1:0]   img_h = '0;
    logic [2:0]       layout_sel = '0;
    logic             out_valid;
    logic [OFF_W-1:0] offset;
    logic             err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tile_addr_gen #(.X_W(X_W), .Y_W(Y_W), .H_W(H_W), .OFF_W(OFF_W)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .px_x(px_x), .px_y(px_y),
        .bpp_code(bpp_code), .img_h(img_h), .layout_sel(layout_sel),
        .out_valid(out_valid), .offset(offset), .err(err)
    );

    task automatic check(input string tag, input logic v, input logic [OFF_W-1:0] o,
                         input logic e);
        total++;
        if (out_valid !== v || offset !== o || err !== e) begin
            bad++;
            $display("FAIL %s: got v=%0b off=%0d err=%0b, want v=%0b off=%0d err=%0b",
                     tag, out_valid, offset, err, v, o, e);
        end
    endtask

    // Issue one request at a falling edge; result appears after the next rising edge.
    task automatic req(input string tag, input int x, input int y, input int code,
                       input int h, input int lay, input int exp_off, input logic exp_err);
        @(negedge clk);
        px_x = X_W'(x); px_y = Y_W'(y); bpp_code = 3'(code);
        img_h = H_W'(h); layout_sel = 3'(lay); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, 1'b1, OFF_W'(exp_off), exp_err);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R11 reset", 1'b0, '0, 1'b0);
    endtask

    task automatic t_utile();
        req("R3 4B inside tile",   2, 1, 2, 64, 0, 24, 1'b0);
        req("R3 16B inside tile",  1, 1, 4, 64, 0, 48, 1'b0);
        req("R4 4B third tile",    9, 2, 2, 64, 0, 164, 1'b0);
        req("R4 1B second row",    3, 13, 0, 64, 0, 107, 1'b0);
        req("R4 16B column",       0, 5, 4, 64, 0, 160, 1'b0);
        req("R5 both indices",     4, 4, 2, 64, 0, 0, 1'b1);
    endtask

    task automatic t_block();
        req("R6 right quadrant",   5, 2, 2, 64, 1, 100, 1'b0);
        req("R6 lower quadrant",   1, 6, 2, 64, 1, 164, 1'b0);
        req("R6 both quadrants",   7, 7, 2, 64, 1, 252, 1'b0);
        req("R7 one column",       3, 17, 2, 64, 1, 540, 1'b0);
        req("R7 two columns",      3, 17, 2, 64, 2, 1052, 1'b0);
        req("R7 two columns bx1",  9, 8, 2, 64, 2, 772, 1'b0);
    endtask

    task automatic t_group();
        req("R8 group h20",        40, 9, 2, 20, 3, 4368, 1'b0);
        req("R8 group h16",        40, 9, 2, 16, 3, 3344, 1'b0);
        req("R8 group first col",  3, 17, 2, 20, 3, 2076, 1'b0);
        req("R9 swizzle even grp", 3, 17, 2, 20, 4, 2076, 1'b0);
        req("R9 swizzle odd grp",  40, 9, 2, 20, 4, 20752, 1'b0);
    endtask

    task automatic t_illegal();
        req("R1 code 5",           1, 1, 5, 64, 0, 0, 1'b1);
        req("R1 code 7",           9, 3, 7, 64, 3, 0, 1'b1);
        req("R2 layout 6",         1, 1, 2, 64, 6, 0, 1'b1);
    endtask

    task automatic t_hold();
        req("R10 setup",           5, 2, 2, 64, 1, 100, 1'b0);
        px_x = 12'd7; px_y = 12'd7; layout_sel = 3'd0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 idle hold", 1'b0, OFF_W'(100), 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 in reset", 1'b0, '0, 1'b0);
        rst = 1'b0;
        t_reset();
        t_utile();
        t_block();
        t_group();
        t_illegal();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: got timeout, want completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule